// File: doc/BRIEF.md
# Power-Up Reset and Strap Sequencer

This block brings a chip out of power-up in timed stages. Once the supply is reported good, it counts reference-clock cycles in place of the analog settling of the core regulator and then the start-up of the crystal oscillator. After that it holds the internal chip reset low for one more fixed interval. The cycle counts come from time parameters and the clock frequency, rounded up to whole cycles. When the internal reset is released, the block captures the configuration strap pins into a held word that the clock-configuration logic reads. It also reports whether the straps moved during the setup window just before the release.

The PLL bypass control stays asserted until two things are true: the clock is valid and the boot flow reports that its secondary phase has started. An external active-low reset request may arrive at any time after the clock is valid. It passes through a synchronizer and sends the sequencer back to the reset-hold stage, so the full hold interval is applied again and the straps are captured again. All pins are plain level signals and there is no streaming interface. The status vector is one-hot: bit 0 regulator wait, bit 1 oscillator wait, bit 2 reset hold, bit 3 running with PLL bypassed, bit 4 running with PLL in use.

Top module: `pwrup_strap_seq`

## Requirements
- R1: While `supply_ok` is low the outputs are: `sys_rst_n`=0, `pll_bypass`=1, `clk_ok`=0, `strap_word`=0, `strap_err`=0 and `state_oh`=5'b00001.
- R2: After `supply_ok` rises, the regulator-wait state lasts exactly REG_CYC = ceil(REG_NS*CLK_HZ/1e9) clock edges. With the defaults this is 7800. The block then moves to oscillator wait.
- R3: Oscillator wait lasts exactly OSC_CYC = ceil(OSC_NS*CLK_HZ/1e9) edges (4680 by default) and then enters reset hold. `clk_ok` is 0 in both wait states and 1 from reset hold onward.
- R4: Reset hold keeps `sys_rst_n` low for HOLD_CYC = ceil(HOLD_NS*CLK_HZ/1e9) consecutive edges (29 by default) at which the synchronized request is inactive. It then enters the bypassed run state, and `sys_rst_n` goes to 1.
- R5: `strap_word` takes the value of `strap_i` at the release edge and does not change at any other edge.
- R6: The setup window is the last STRAP_CYC = ceil(STRAP_NS*CLK_HZ/1e9) edges of reset hold (3 by default), the release edge included. At each release, `strap_err` is loaded with 1 if `strap_i` differed from its value at the first window edge at any later edge of the window, and with 0 otherwise. It holds that value until the next release. A change made before the first window edge does not set it.
- R7: `rst_req_n` passes through a two-stage synchronizer. If it goes low while the block is running, state `state_oh` shows reset hold and `sys_rst_n` is 0 after the third edge. The block stays in reset hold while the request is low. It releases at the (HOLD_CYC+2)-th edge after the request returns high. A request during either wait state does not change the length of that state.
- R8: `pll_bypass` is 1 in every state except PLL run. The bypassed run state lasts at least one edge. It moves to PLL run at the first edge in that state at which `boot2_i` is 1, and `boot2_i` has no effect in any other state.
- R9: `state_oh` always has exactly one bit set, using the bit order given above.
- R10: A reset request taken while in PLL run sets `pll_bypass` back to 1 on the same edge at which `sys_rst_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| supply_ok | input | 1 | Supply good; low resets the whole block asynchronously |
| rst_req_n | input | 1 | External reset request, active low, asynchronous |
| strap_i | input | 3 | Configuration strap pins |
| boot2_i | input | 1 | Secondary boot phase has started |
| sys_rst_n | output | 1 | Internal chip reset, active low |
| strap_word | output | 3 | Straps captured at the last release |
| strap_err | output | 1 | Straps moved inside the setup window before the last release |
| pll_bypass | output | 1 | PLL bypass control, 1 = bypassed |
| clk_ok | output | 1 | Reference clock considered stable |
| state_oh | output | 5 | One-hot sequencer state |

## Verification
The bench measures how long each state lasts and compares the result with the rounded-up cycle counts. A counter that is off by one, or that forgets to restart between stages, shows up as a segment one edge too long or too short. Strap edits are placed at the edge just before the setup window and at its second edge. A window placed one edge wrong would either raise a false `strap_err` or miss a real violation, and would latch the wrong word. Reset requests are issued from both run states, including one whose reset hold carries a late strap edit. This checks the three-edge synchronizer latency, the full re-applied hold, the return of PLL bypass, and the clearing of `strap_err` at the next clean release. `boot2_i` is held high from power-up to catch a design that skips the bypassed run state.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int NUM_ST = 5;

  typedef enum logic [2:0] {
    ST_REG  = 3'd0,
    ST_OSC  = 3'd1,
    ST_HOLD = 3'd2,
    ST_RUNB = 3'd3,
    ST_RUNP = 3'd4
  } pss_state_e;

  // Whole reference cycles covering a time in nanoseconds, rounded up.
  function automatic longint cyc_ceil(input longint ns, input longint hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= RST_VAL;
      else        sh <= d;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d};
    end
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter longint REG_CYC   = 7800,
  parameter longint OSC_CYC   = 4680,
  parameter longint HOLD_CYC  = 29,
  parameter longint STRAP_CYC = 3,
  parameter int     CW        = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_ok_i,
  input  logic       boot2_i,
  output pss_state_e state_o,
  output logic       rel_o,
  output logic       win_start_o,
  output logic       win_in_o
);

  localparam logic [CW-1:0] REG_LAST  = CW'(REG_CYC - 1);
  localparam logic [CW-1:0] OSC_LAST  = CW'(OSC_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] WIN_FIRST = CW'(HOLD_CYC - STRAP_CYC);

  pss_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_cnt;

  assign hold_cnt = (state_q == ST_HOLD) && req_ok_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      ST_REG: if (cnt_q == REG_LAST) begin
        state_d = ST_OSC;
        cnt_d   = '0;
      end
      ST_OSC: if (cnt_q == OSC_LAST) begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end
      ST_HOLD: begin
        if (!req_ok_i) begin
          cnt_d = '0;
        end else if (cnt_q == HOLD_LAST) begin
          state_d = ST_RUNB;
          cnt_d   = '0;
        end
      end
      ST_RUNB: begin
        cnt_d = '0;
        if (!req_ok_i)    state_d = ST_HOLD;
        else if (boot2_i) state_d = ST_RUNP;
      end
      ST_RUNP: begin
        cnt_d = '0;
        if (!req_ok_i) state_d = ST_HOLD;
      end
      default: begin
        state_d = ST_REG;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REG;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o     = state_q;
  assign rel_o       = hold_cnt && (cnt_q == HOLD_LAST);
  assign win_start_o = hold_cnt && (cnt_q == WIN_FIRST);
  assign win_in_o    = hold_cnt && (cnt_q > WIN_FIRST) && (cnt_q < HOLD_LAST);

  assert_reg_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REG && cnt_q != REG_LAST) |=> state_q == ST_REG);

  assert_osc_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OSC) |=> (state_q == ST_OSC || state_q == ST_HOLD));

  assert_hold_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && cnt_q != HOLD_LAST) |=> state_q == ST_HOLD);

  assert_req_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUNB || state_q == ST_RUNP) && !req_ok_i) |=> state_q == ST_HOLD);

  assert_bypass_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUNB && req_ok_i && !boot2_i) |=> state_q == ST_RUNB);

  assert_no_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> state_q != ST_RUNP);

endmodule

// File: rtl/pss_strap.sv
module pss_strap #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap_i,
  input  logic         win_start_i,
  input  logic         win_in_i,
  input  logic         rel_i,
  output logic [W-1:0] word_o,
  output logic         err_o
);

  logic [W-1:0] snap_q, word_q;
  logic         moved_q, err_q, moved_now;

  // On a one-edge window the start edge is the release edge: nothing to compare.
  assign moved_now = !win_start_i && (strap_i != snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      moved_q <= 1'b0;
      word_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (win_start_i) begin
        snap_q  <= strap_i;
        moved_q <= 1'b0;
      end else if (win_in_i && moved_now) begin
        moved_q <= 1'b1;
      end
      if (rel_i) begin
        word_q <= strap_i;
        err_q  <= moved_q || moved_now;
      end
    end
  end

  assign word_o = word_q;
  assign err_o  = err_q;

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_i |=> $stable(word_q));

  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_i |=> $stable(err_q));

endmodule

// File: rtl/pwrup_strap_seq.sv
module pwrup_strap_seq
  import pss_pkg::*;
#(
  parameter longint CLK_HZ   = 26_000_000,
  parameter longint REG_NS   = 300_000,
  parameter longint OSC_NS   = 180_000,
  parameter longint HOLD_NS  = 1_100,
  parameter longint STRAP_NS = 100,
  parameter int     NSTRAP   = 3,
  parameter int     SYNC_STG = 2
) (
  input  logic              clk_ref,
  input  logic              supply_ok,
  input  logic              rst_req_n,
  input  logic [NSTRAP-1:0] strap_i,
  input  logic              boot2_i,
  output logic              sys_rst_n,
  output logic [NSTRAP-1:0] strap_word,
  output logic              strap_err,
  output logic              pll_bypass,
  output logic              clk_ok,
  output logic [NUM_ST-1:0] state_oh
);

  localparam longint REG_CYC   = cyc_ceil(REG_NS, CLK_HZ);
  localparam longint OSC_CYC   = cyc_ceil(OSC_NS, CLK_HZ);
  localparam longint HOLD_CYC  = cyc_ceil(HOLD_NS, CLK_HZ);
  localparam longint STRAP_CYC = cyc_ceil(STRAP_NS, CLK_HZ);
  localparam longint MAX_AB    = (REG_CYC > OSC_CYC) ? REG_CYC : OSC_CYC;
  localparam longint MAX_CYC   = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int     CW        = $clog2(MAX_CYC + 1);

  logic       req_ok, rel, win_start, win_in;
  pss_state_e state;

  pss_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk_ref),
    .rst_n (supply_ok),
    .d     (rst_req_n),
    .q     (req_ok)
  );

  pss_fsm #(
    .REG_CYC   (REG_CYC),
    .OSC_CYC   (OSC_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .STRAP_CYC (STRAP_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk         (clk_ref),
    .rst_n       (supply_ok),
    .req_ok_i    (req_ok),
    .boot2_i     (boot2_i),
    .state_o     (state),
    .rel_o       (rel),
    .win_start_o (win_start),
    .win_in_o    (win_in)
  );

  pss_strap #(.W(NSTRAP)) u_strap (
    .clk         (clk_ref),
    .rst_n       (supply_ok),
    .strap_i     (strap_i),
    .win_start_i (win_start),
    .win_in_i    (win_in),
    .rel_i       (rel),
    .word_o      (strap_word),
    .err_o       (strap_err)
  );

  assign sys_rst_n  = (state == ST_RUNB) || (state == ST_RUNP);
  assign pll_bypass = (state != ST_RUNP);
  assign clk_ok     = (state == ST_HOLD) || sys_rst_n;
  assign state_oh   = NUM_ST'(1) << state;

  assert_reset_bypass_R10: assert property (@(posedge clk_ref) disable iff (!supply_ok)
    !sys_rst_n |-> pll_bypass);

  assert_run_clk_R3: assert property (@(posedge clk_ref) disable iff (!supply_ok)
    sys_rst_n |-> clk_ok);

  assert_release_capture_R5: assert property (@(posedge clk_ref) disable iff (!supply_ok)
    $rose(sys_rst_n) |-> strap_word == $past(strap_i));

  assert_state_onehot_R9: assert property (@(posedge clk_ref) disable iff (!supply_ok)
    $countones(state_oh) == 1);

endmodule

// File: tb/pwrup_strap_seq_tb.sv
`timescale 1ns/1ps
module pwrup_strap_seq_tb;

  localparam longint HZ      = 26_000_000;
  localparam int     REG_C   = int'((300_000 * HZ + 999_999_999) / 1_000_000_000);
  localparam int     OSC_C   = int'((180_000 * HZ + 999_999_999) / 1_000_000_000);
  localparam int     HOLD_C  = int'((1_100 * HZ + 999_999_999) / 1_000_000_000);
  localparam int     STRAP_C = int'((100 * HZ + 999_999_999) / 1_000_000_000);
  localparam int     W0      = HOLD_C - STRAP_C + 2;  // waits after req rise to hit first window edge

  localparam logic [4:0] OH_REG  = 5'b00001;
  localparam logic [4:0] OH_OSC  = 5'b00010;
  localparam logic [4:0] OH_HOLD = 5'b00100;
  localparam logic [4:0] OH_RUNB = 5'b01000;
  localparam logic [4:0] OH_RUNP = 5'b10000;

  logic       clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic       rst_req_n = 1'b1;
  logic [2:0] strap_i = 3'b101;
  logic       boot2_i = 1'b1;
  logic       sys_rst_n, strap_err, pll_bypass, clk_ok;
  logic [2:0] strap_word;
  logic [4:0] state_oh;

  int checks = 0;
  int bad    = 0;

  always #2.5 clk = ~clk;

  pwrup_strap_seq u_dut (
    .clk_ref    (clk),
    .supply_ok  (supply_ok),
    .rst_req_n  (rst_req_n),
    .strap_i    (strap_i),
    .boot2_i    (boot2_i),
    .sys_rst_n  (sys_rst_n),
    .strap_word (strap_word),
    .strap_err  (strap_err),
    .pll_bypass (pll_bypass),
    .clk_ok     (clk_ok),
    .state_oh   (state_oh)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic string seg_tag(input logic [4:0] oh);
    case (oh)
      OH_REG:  return "R2 regulator wait";
      OH_OSC:  return "R3 oscillator wait";
      OH_HOLD: return "R4/R7 reset hold";
      OH_RUNB: return "R8 bypassed run";
      default: return "R9 state";
    endcase
  endfunction

  // Scoreboard queues: expected state segments and expected captures.
  logic [4:0] q_oh[$];
  int         q_len[$];   // 0 = length not checked
  logic [2:0] q_word[$];
  logic       q_err[$];

  task automatic push_seg(input logic [4:0] oh, input int len);
    q_oh.push_back(oh);
    q_len.push_back(len);
  endtask

  task automatic push_cap(input logic [2:0] w, input logic e);
    q_word.push_back(w);
    q_err.push_back(e);
  endtask

  // Monitor
  logic [4:0] cur_oh;
  int         run_len;
  logic       prev_rst;

  always @(negedge clk) begin
    if (!supply_ok) begin
      cur_oh   = state_oh;
      run_len  = 1;   // counts the first edge after supply release
      prev_rst = 1'b0;
    end else begin
      if (state_oh == cur_oh) begin
        run_len++;
      end else begin
        if (q_oh.size() == 0) begin
          chk("R9 unexpected state change", int'(state_oh), 0);
        end else begin
          logic [4:0] e_oh;
          int         e_len;
          e_oh  = q_oh.pop_front();
          e_len = q_len.pop_front();
          chk(seg_tag(e_oh), int'(cur_oh), int'(e_oh));
          if (e_len != 0) chk(seg_tag(e_oh), run_len, e_len);
        end
        cur_oh  = state_oh;
        run_len = 1;
      end
      if (sys_rst_n && !prev_rst) begin
        if (q_word.size() == 0) begin
          chk("R5 unexpected release", 1, 0);
        end else begin
          logic [2:0] e_w;
          logic       e_e;
          e_w = q_word.pop_front();
          e_e = q_err.pop_front();
          chk("R5 strap word", int'(strap_word), int'(e_w));
          chk("R6 strap error", int'(strap_err), int'(e_e));
        end
      end
      prev_rst = sys_rst_n;
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Reset request held low for n negedges (n >= 3) from a run state;
  // optional strap change k negedges after the request rises.
  task automatic req_pulse(input int n, input int k, input logic [2:0] nw);
    rst_req_n = 1'b0;
    wait_neg(2);
    chk("R7 two-edge latency, still running", int'(sys_rst_n), 1);
    wait_neg(1);
    chk("R7 reset after third edge", int'(sys_rst_n), 0);
    chk("R10 bypass back on", int'(pll_bypass), 1);
    chk("R9 hold status", int'(state_oh), int'(OH_HOLD));
    wait_neg(n - 3);
    rst_req_n = 1'b1;
    if (k >= 0) begin
      wait_neg(k);
      strap_i = nw;
    end
  endtask

  task automatic wait_state(input logic [4:0] oh);
    while (state_oh != oh) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog R1-seq act=hung exp=done");
    finish_run();
  end

  initial begin
    wait_neg(3);
    // Reset state
    chk("R1 sys_rst_n", int'(sys_rst_n), 0);
    chk("R1 pll_bypass", int'(pll_bypass), 1);
    chk("R1 clk_ok", int'(clk_ok), 0);
    chk("R1 strap_word", int'(strap_word), 0);
    chk("R1 strap_err", int'(strap_err), 0);
    chk("R9 reset status", int'(state_oh), int'(OH_REG));

    // Scenario 1: power-up, boot flag already high, straps steady
    push_seg(OH_REG, REG_C);
    push_seg(OH_OSC, OSC_C);
    push_seg(OH_HOLD, HOLD_C);
    push_seg(OH_RUNB, 1);
    push_seg(OH_RUNP, 0);
    push_cap(3'b101, 1'b0);
    supply_ok = 1'b1;
    wait_neg(100);
    rst_req_n = 1'b0;           // ignored in regulator wait (R7)
    wait_neg(5);
    rst_req_n = 1'b1;
    chk("R3 clk_ok low in regulator wait", int'(clk_ok), 0);
    wait_state(OH_OSC);
    chk("R3 clk_ok low in oscillator wait", int'(clk_ok), 0);
    wait_state(OH_RUNP);
    chk("R8 bypass off in PLL run", int'(pll_bypass), 0);
    chk("R3 clk_ok in run", int'(clk_ok), 1);

    // Scenario 2: straps move while running, then request with an early edit
    boot2_i = 1'b0;
    strap_i = 3'b011;
    wait_neg(4);
    chk("R5 word held while running", int'(strap_word), 3'b101);
    push_seg(OH_HOLD, 10 + HOLD_C - 1);
    push_seg(OH_RUNB, 6);
    push_seg(OH_RUNP, 0);
    push_cap(3'b110, 1'b0);
    req_pulse(10, W0, 3'b110);
    wait_state(OH_RUNB);
    wait_neg(2);
    chk("R8 bypass held without boot flag", int'(pll_bypass), 1);
    chk("R9 bypassed run status", int'(state_oh), int'(OH_RUNB));
    wait_neg(3);
    boot2_i = 1'b1;
    wait_state(OH_RUNP);

    // Scenario 3: late strap edit inside the window
    push_seg(OH_HOLD, 4 + HOLD_C - 1);
    push_seg(OH_RUNB, 1);
    push_seg(OH_RUNP, 0);
    push_cap(3'b001, 1'b1);
    req_pulse(4, W0 + 1, 3'b001);
    wait_state(OH_RUNP);
    chk("R6 error flag held after release", int'(strap_err), 1);

    // Scenario 4: clean release clears the error
    push_seg(OH_HOLD, 5 + HOLD_C - 1);
    push_seg(OH_RUNB, 1);
    push_seg(OH_RUNP, 0);
    push_cap(3'b001, 1'b0);
    req_pulse(5, -1, 3'b000);
    wait_state(OH_RUNP);
    wait_neg(4);
    chk("R9 only open run segment left", q_oh.size(), 1);
    chk("R5 all captures seen", q_word.size(), 0);
    finish_run();
  end

endmodule